// File: doc/BRIEF.md
# ADC Peripheral Host Register Interface

This block is the host-facing register bank of an analog-to-digital converter peripheral. It answers 16-bit host bus cycles with byte-lane strobes, holds the configuration, interrupt, test, pin-direction, pin-data, control and status words, and hands the control words and pin settings to the rest of the peripheral. Hosts that issue long-word or wider transfers break them into back-to-back 16-bit cycles. Each half is an ordinary access, so a status update from the sequencer can land between the two halves.

Some locations are shared with the conversion sequencer. When the host reaches one of them while the sequencer holds it, the handshake stretches by one to four wait states. A STOP bit in the configuration word turns off the converter clock enable and fires a one-cycle abort pulse towards the conversion queue. While STOP is set, each register group follows its own policy. The open group stays fully accessible. The frozen group keeps its contents but ignores writes. The held group is forced to zero and ignores writes.

Top module: `adc_host_regs`

## Requirements
- R1: An access to any location other than a shared one, or to a shared one with `seq_busy` low in the request cycle, raises `rdy` for exactly one cycle in the second cycle of the request (request cycle plus one).
- R2: The shared locations are word addresses 5 to 8. If `seq_busy` is high during the first L cycles of such an access, counting the request cycle, `rdy` comes min(L,4) cycles later than under R1, so there are never more than four wait states.
- R3: Byte lanes: `be[1]` writes bits 15:8 and `be[0]` writes bits 7:0. A lane whose strobe is low keeps its old value.
- R4: Word addresses and implemented bits: 0 configuration 0x800F, 1 interrupt 0x07FF, 2 test 0x00FF, 3 direction 0x00FF, 4 pin data 0xFFFF, 5 control0 0x00FF, 6 control1 0xF0F0, 7 control2 0xBF7F, 8 status 0xC0FF. Unimplemented bits read as zero and ignore writes. After reset every register reads zero.
- R5: An access to word addresses 9 and up completes with R1 timing, returns zero and changes no register.
- R6: STOP is configuration bit 15. `conv_clk_en` is the inverse of STOP. `abort` is high for exactly the one cycle in which STOP first reads as 1 after being 0.
- R7: While STOP is set, the configuration, interrupt and test registers can still be written and read.
- R8: While STOP is set, writes to the direction and pin-data registers are ignored, and those registers keep their contents.
- R9: While STOP is set, control0 to control2 and status read zero and ignore writes. One clock after STOP is cleared, they accept writes again.
- R10: Each cycle, `stat_set` bits within the status mask are ORed into the status register, except while STOP is set.
- R11: Two consecutive 16-bit reads are independent. A status update that arrives between them shows in the second read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, held until `rdy` |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| be | input | 2 | Byte-lane strobes (upper, lower) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while `rdy` is high |
| rdy | output | 1 | Access completes this cycle |
| seq_busy | input | 1 | Sequencer holds the shared locations |
| stat_set | input | 16 | Status bits set by the sequencer |
| conv_clk_en | output | 1 | Converter clock enable |
| abort | output | 1 | One-cycle conversion abort pulse |
| ctrl0_o | output | 16 | Control word 0 |
| ctrl1_o | output | 16 | Control word 1 |
| ctrl2_o | output | 16 | Control word 2 |
| ddr_o | output | 16 | Pin direction word |
| port_o | output | 16 | Pin data word |

## Verification
A stuck or mis-sequenced handshake state shows within a few cycles as an access whose `rdy` comes at the wrong cycle count or never comes. A wrong group policy while stopped shows on the next cycle at `ctrl*_o`, `ddr_o` or `port_o`, or on the next read. A missed or repeated STOP edge shows as a wrong `abort` width in the cycle right after the configuration write. A masking or lane error stays hidden until the affected word is read back, so every access is followed by a comparison of all output words against a model.

// File: rtl/adc_rif_pkg.sv
package adc_rif_pkg;

    localparam int DW       = 16;
    localparam int NREG     = 9;
    localparam int IW       = $clog2(NREG);
    localparam int STOP_BIT = 15;

    localparam int IX_CFG  = 0;
    localparam int IX_INT  = 1;
    localparam int IX_TST  = 2;
    localparam int IX_DDR  = 3;
    localparam int IX_PORT = 4;
    localparam int IX_CR0  = 5;
    localparam int IX_CR1  = 6;
    localparam int IX_CR2  = 7;
    localparam int IX_STAT = 8;

    // Stop-mode policy of a register group
    typedef enum logic [1:0] {
        GRP_OPEN   = 2'd0,
        GRP_FROZEN = 2'd1,
        GRP_HELD   = 2'd2
    } grp_e;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_WAIT = 2'd1,
        BUS_ACK  = 2'd2
    } bus_st_e;

    typedef struct packed {
        logic          valid;
        logic          shared;
        logic [IW-1:0] idx;
    } dec_t;

    function automatic logic [DW-1:0] reg_mask(input int idx);
        case (idx)
            IX_CFG:  return 16'h800F;
            IX_INT:  return 16'h07FF;
            IX_TST:  return 16'h00FF;
            IX_DDR:  return 16'h00FF;
            IX_PORT: return 16'hFFFF;
            IX_CR0:  return 16'h00FF;
            IX_CR1:  return 16'hF0F0;
            IX_CR2:  return 16'hBF7F;
            IX_STAT: return 16'hC0FF;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic grp_e reg_grp(input int idx);
        if (idx <= IX_TST)       return GRP_OPEN;
        else if (idx <= IX_PORT) return GRP_FROZEN;
        else                     return GRP_HELD;
    endfunction

    function automatic dec_t addr_decode(input logic [31:0] a);
        dec_t d;
        d.valid  = (a < NREG);
        d.shared = d.valid && (a >= IX_CR0);
        d.idx    = a[IW-1:0];
        return d;
    endfunction

    function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_v,
                                                 input logic [DW-1:0] new_v,
                                                 input logic [1:0]    be,
                                                 input logic [DW-1:0] mask);
        logic [DW-1:0] r;
        r = old_v;
        if (be[1]) r[DW-1:DW/2] = new_v[DW-1:DW/2];
        if (be[0]) r[DW/2-1:0]  = new_v[DW/2-1:0];
        return r & mask;
    endfunction

endpackage

// File: rtl/adc_rif_bus.sv
module adc_rif_bus
    import adc_rif_pkg::*;
#(
    parameter int WAIT_MAX = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic shared_hit,
    input  logic seq_busy,
    output logic rdy
);
    localparam int CW = $clog2(WAIT_MAX + 1);

    bus_st_e       st_q;
    logic [CW-1:0] wcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= BUS_IDLE;
            wcnt_q <= '0;
        end else begin
            case (st_q)
                BUS_IDLE: begin
                    if (req) begin
                        if (shared_hit && seq_busy) begin
                            st_q   <= BUS_WAIT;
                            wcnt_q <= CW'(1);
                        end else begin
                            st_q <= BUS_ACK;
                        end
                    end
                end
                BUS_WAIT: begin
                    if (seq_busy && (wcnt_q < CW'(WAIT_MAX))) begin
                        wcnt_q <= wcnt_q + CW'(1);
                    end else begin
                        st_q <= BUS_ACK;
                    end
                end
                BUS_ACK:  st_q <= BUS_IDLE;
                default:  st_q <= BUS_IDLE;
            endcase
        end
    end

    assign rdy = (st_q == BUS_ACK);

endmodule

// File: rtl/adc_rif_regs.sv
module adc_rif_regs
    import adc_rif_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [IW-1:0]          idx,
    input  logic [1:0]             be,
    input  logic [DW-1:0]          wdata,
    input  logic [DW-1:0]          stat_set,
    output logic [NREG-1:0][DW-1:0] regs_o,
    output logic                   stop
);
    assign stop = regs_o[IX_CFG][STOP_BIT];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [DW-1:0] MASK = reg_mask(i);
        localparam grp_e          GRP  = reg_grp(i);

        logic [DW-1:0] q;
        logic [DW-1:0] nxt;
        logic          hit;

        assign hit = wr_en && (idx == IW'(i));

        always_comb begin
            nxt = q;
            if (hit && ((GRP == GRP_OPEN) || !stop)) begin
                nxt = lane_merge(q, wdata, be, MASK);
            end
            if (i == IX_STAT) begin
                nxt = nxt | (stat_set & MASK);
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if ((GRP == GRP_HELD) && stop) begin
                q <= '0;
            end else begin
                q <= nxt;
            end
        end

        assign regs_o[i] = q;
    end

endmodule

// File: rtl/adc_rif_stop.sv
module adc_rif_stop (
    input  logic clk,
    input  logic rst,
    input  logic stop,
    output logic conv_clk_en,
    output logic abort
);
    logic stop_d;

    always_ff @(posedge clk) begin
        if (rst) stop_d <= 1'b0;
        else     stop_d <= stop;
    end

    assign abort       = stop && !stop_d;
    assign conv_clk_en = !stop;

endmodule

// File: rtl/adc_host_regs.sv
module adc_host_regs
    import adc_rif_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int WAIT_MAX = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        be,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              rdy,
    input  logic              seq_busy,
    input  logic [15:0]       stat_set,
    output logic              conv_clk_en,
    output logic              abort,
    output logic [15:0]       ctrl0_o,
    output logic [15:0]       ctrl1_o,
    output logic [15:0]       ctrl2_o,
    output logic [15:0]       ddr_o,
    output logic [15:0]       port_o
);
    dec_t                    dec;
    logic                    wr_en;
    logic                    stop;
    logic [NREG-1:0][DW-1:0] regs;

    assign dec   = addr_decode(32'(addr));
    assign wr_en = rdy && wr && dec.valid;

    adc_rif_bus #(.WAIT_MAX(WAIT_MAX)) u_bus (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .shared_hit (dec.shared),
        .seq_busy   (seq_busy),
        .rdy        (rdy)
    );

    adc_rif_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .idx      (dec.idx),
        .be       (be),
        .wdata    (wdata),
        .stat_set (stat_set),
        .regs_o   (regs),
        .stop     (stop)
    );

    adc_rif_stop u_stop (
        .clk         (clk),
        .rst         (rst),
        .stop        (stop),
        .conv_clk_en (conv_clk_en),
        .abort       (abort)
    );

    assign rdata   = (rdy && dec.valid) ? regs[dec.idx] : '0;
    assign ctrl0_o = regs[IX_CR0];
    assign ctrl1_o = regs[IX_CR1];
    assign ctrl2_o = regs[IX_CR2];
    assign ddr_o   = regs[IX_DDR];
    assign port_o  = regs[IX_PORT];

endmodule

// File: rtl/adc_host_regs_chk.sv
module adc_host_regs_chk #(
    parameter int ADDR_W   = 4,
    parameter int WAIT_MAX = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       rdata,
    input logic              rdy,
    input logic              seq_busy,
    input logic              conv_clk_en,
    input logic              abort,
    input logic [15:0]       ctrl0_o,
    input logic [15:0]       ctrl1_o,
    input logic [15:0]       ctrl2_o,
    input logic [15:0]       ddr_o,
    input logic [15:0]       port_o
);
    logic       in_acc_q;
    logic [7:0] pend_q;
    logic       shared_a;
    logic       unmapped_a;

    assign shared_a   = (32'(addr) >= 5) && (32'(addr) <= 8);
    assign unmapped_a = (32'(addr) >= 9);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_acc_q <= 1'b0;
            pend_q   <= '0;
        end else begin
            in_acc_q <= req && !rdy;
            if (req && !rdy && (pend_q != 8'hFF)) pend_q <= pend_q + 8'd1;
            else if (!req || rdy)                 pend_q <= '0;
        end
    end

    assert_fast_ack_R1: assert property (@(posedge clk) disable iff (rst)
        (req && !in_acc_q && !(shared_a && seq_busy)) |=> rdy);

    assert_ack_single_R1: assert property (@(posedge clk) disable iff (rst)
        rdy |=> !rdy);

    assert_contend_stretch_R2: assert property (@(posedge clk) disable iff (rst)
        (req && !in_acc_q && shared_a && seq_busy) |=> !rdy);

    assert_wait_cap_R2: assert property (@(posedge clk) disable iff (rst)
        pend_q <= 8'(WAIT_MAX + 1));

    assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (rdy && unmapped_a) |-> (rdata == 16'h0000));

    assert_abort_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        abort |=> !abort);

    assert_abort_on_stop_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_clk_en) |-> abort);

    assert_held_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !conv_clk_en |=> (ctrl0_o == 16'h0 && ctrl1_o == 16'h0 && ctrl2_o == 16'h0));

    assert_frozen_pins_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(conv_clk_en) |-> ($stable(port_o) && $stable(ddr_o)));

endmodule

bind adc_host_regs adc_host_regs_chk #(.ADDR_W(ADDR_W), .WAIT_MAX(WAIT_MAX)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .addr        (addr),
    .rdata       (rdata),
    .rdy         (rdy),
    .seq_busy    (seq_busy),
    .conv_clk_en (conv_clk_en),
    .abort       (abort),
    .ctrl0_o     (ctrl0_o),
    .ctrl1_o     (ctrl1_o),
    .ctrl2_o     (ctrl2_o),
    .ddr_o       (ddr_o),
    .port_o      (port_o)
);

// File: tb/adc_host_regs_tb.sv
`timescale 1ns/1ps
module adc_host_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [1:0]  be = 2'b11;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rdy;
    logic        seq_busy = 1'b0;
    logic [15:0] stat_set = '0;
    logic        conv_clk_en;
    logic        abort;
    logic [15:0] ctrl0_o, ctrl1_o, ctrl2_o, ddr_o, port_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] mdl [9];

    always #5 clk = ~clk;

    adc_host_regs dut_i (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .be(be),
        .wdata(wdata), .rdata(rdata), .rdy(rdy), .seq_busy(seq_busy),
        .stat_set(stat_set), .conv_clk_en(conv_clk_en), .abort(abort),
        .ctrl0_o(ctrl0_o), .ctrl1_o(ctrl1_o), .ctrl2_o(ctrl2_o),
        .ddr_o(ddr_o), .port_o(port_o)
    );

    function automatic logic [15:0] b_mask(input int a);
        case (a)
            0: return 16'h800F;  1: return 16'h07FF;  2: return 16'h00FF;
            3: return 16'h00FF;  4: return 16'hFFFF;  5: return 16'h00FF;
            6: return 16'hF0F0;  7: return 16'hBF7F;  8: return 16'hC0FF;
            default: return 16'h0000;
        endcase
    endfunction

    // 0 = open, 1 = frozen while stopped, 2 = held in reset while stopped
    function automatic int b_grp(input int a);
        return (a <= 2) ? 0 : ((a <= 4) ? 1 : 2);
    endfunction

    function automatic int b_waits(input int a, input int l);
        if (a < 5 || a > 8) return 0;
        return (l > 4) ? 4 : l;
    endfunction

    function automatic logic [15:0] b_lanes(input logic [1:0] b);
        return {b[1] ? 8'hFF : 8'h00, b[0] ? 8'hFF : 8'h00};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk("R9 ctrl0", ctrl0_o, mdl[5]);
        chk("R9 ctrl1", ctrl1_o, mdl[6]);
        chk("R9 ctrl2", ctrl2_o, mdl[7]);
        chk("R8 ddr", ddr_o, mdl[3]);
        chk("R8 port", port_o, mdl[4]);
        chk("R6 clk_en", {15'd0, conv_clk_en}, {15'd0, !mdl[0][15]});
    endtask

    task automatic access(input string tag, input logic w, input int a, input logic [1:0] b,
                          input logic [15:0] d, input int l, output logic [15:0] got);
        int cyc;
        bit done;
        logic old_stop;
        logic [15:0] exp_rd;
        cyc = 0;
        done = 0;
        got = '0;
        exp_rd = (a < 9) ? mdl[a] : 16'h0;
        @(posedge clk); #1;
        req = 1'b1; wr = w; addr = 4'(a); be = b; wdata = d;
        seq_busy = (l > 0);
        while (!done) begin
            @(negedge clk);
            cyc++;
            if (rdy) begin
                got = rdata;
                done = 1;
            end else if (cyc > 20) begin
                done = 1;
            end else begin
                @(posedge clk); #1;
                seq_busy = (cyc < l);
            end
        end
        chk((b_waits(a, l) == 0) ? "R1 cycles" : "R2 cycles", 16'(cyc), 16'(2 + b_waits(a, l)));
        if (!w) chk(tag, got & b_lanes(b), exp_rd & b_lanes(b));
        old_stop = mdl[0][15];
        if (w && a < 9) begin
            if (b_grp(a) == 0 || !old_stop) begin
                logic [15:0] t;
                t = mdl[a];
                if (b[1]) t[15:8] = d[15:8];
                if (b[0]) t[7:0] = d[7:0];
                mdl[a] = t & b_mask(a);
            end
        end
        @(posedge clk); #1;
        req = 1'b0; wr = 1'b0; seq_busy = 1'b0;
        @(negedge clk);
        chk("R6 abort", {15'd0, abort}, {15'd0, (!old_stop && mdl[0][15])});
        if (mdl[0][15]) for (int k = 5; k <= 8; k++) mdl[k] = 16'h0;
        @(negedge clk);
        check_outputs();
    endtask

    task automatic stat_pulse(input logic [15:0] v);
        @(posedge clk); #1;
        stat_set = v;
        @(posedge clk); #1;
        stat_set = '0;
        if (!mdl[0][15]) mdl[8] = mdl[8] | (v & b_mask(8));
    endtask

    initial begin
        #2_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] r;
        void'($urandom(32'h5EED_0A1C));
        for (int k = 0; k < 9; k++) mdl[k] = 16'h0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R4 reset rdy", {15'd0, rdy}, 16'h0);
        chk("R6 reset abort", {15'd0, abort}, 16'h0);
        check_outputs();
        for (int k = 0; k < 9; k++) access("R4 reset read", 0, k, 2'b11, 0, 0, r);

        // masks and lanes
        for (int k = 0; k < 9; k++) access("R4 write", 1, k, 2'b11, 16'h7FFF, 0, r);
        for (int k = 0; k < 9; k++) access("R4 mask read", 0, k, 2'b11, 0, 0, r);
        access("R3", 1, 6, 2'b10, 16'h0A5A, 0, r);
        access("R3 upper lane", 0, 6, 2'b11, 0, 0, r);
        access("R3", 1, 4, 2'b01, 16'hFF33, 0, r);
        access("R3 lower lane", 0, 4, 2'b11, 0, 0, r);

        // unmapped
        access("R5", 1, 12, 2'b11, 16'hFFFF, 0, r);
        access("R5 unmapped read", 0, 12, 2'b11, 0, 0, r);
        chk("R5 value", r, 16'h0);
        for (int k = 0; k < 9; k++) access("R5 no change", 0, k, 2'b11, 0, 0, r);

        // contention
        for (int l = 0; l <= 6; l++) access("R2 read", 0, 5 + (l % 4), 2'b11, 0, l, r);
        access("R1 unshared busy", 0, 2, 2'b11, 0, 5, r);

        // status set and split reads
        stat_pulse(16'h8001);
        access("R10 stat set", 0, 8, 2'b11, 0, 0, r);
        access("R11 first half", 0, 8, 2'b11, 0, 0, r);
        stat_pulse(16'h4010);
        access("R11 second half", 0, 8, 2'b11, 0, 0, r);

        // stop mode
        access("R6", 1, 0, 2'b11, 16'h8003, 0, r);
        access("R7", 1, 1, 2'b11, 16'h0123, 0, r);
        access("R7 int read", 0, 1, 2'b11, 0, 0, r);
        access("R7", 1, 2, 2'b01, 16'h00C3, 0, r);
        access("R7 test read", 0, 2, 2'b11, 0, 0, r);
        access("R8", 1, 3, 2'b11, 16'h0011, 0, r);
        access("R8 ddr read", 0, 3, 2'b11, 0, 0, r);
        access("R8", 1, 4, 2'b11, 16'h1111, 0, r);
        access("R8 port read", 0, 4, 2'b11, 0, 0, r);
        access("R9", 1, 5, 2'b11, 16'h00AA, 0, r);
        access("R9 held read", 0, 5, 2'b11, 0, 0, r);
        stat_pulse(16'h0001);
        access("R9 stat held", 0, 8, 2'b11, 0, 0, r);
        access("R6 clear", 1, 0, 2'b11, 16'h0000, 0, r);
        access("R9", 1, 5, 2'b11, 16'h0055, 0, r);
        access("R9 release read", 0, 5, 2'b11, 0, 0, r);

        // random mix
        for (int n = 0; n < 400; n++) begin
            int a;
            logic [15:0] d;
            a = $urandom_range(0, 15);
            d = 16'($urandom);
            if (a == 0) d[15] = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 7) == 0) stat_pulse(16'($urandom));
            access((a >= 9) ? "R5 random" : "R4 random", 1'($urandom_range(0, 1)), a,
                   2'($urandom_range(1, 3)), d, $urandom_range(0, 6), r);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule